// File: doc/BRIEF.md
# Physical Page Allocation Bitmap

This block keeps track of which 4 KB physical pages are in use. It stores one bit per page in an internal word-organised memory, where a set bit marks a page as used. Software-facing logic sends it one command at a time. The four commands are: allocate a page from the top of memory, allocate a DMA-safe page from the bottom of memory, free a page, and mark a page as used. Marking pages as used at start-up reserves regions such as low memory.

An allocation scans the map one word per step. A top-down request takes the highest free page. A DMA request takes the lowest free page and never goes past a configurable page limit (16 MB by default). If the DMA window has no free page, the request fails, even when pages above the limit are still free. Every response returns the physical byte address of the page, which is the page index followed by twelve zero bits. A running count of free pages is always visible, and an allocation fails at once when that count is zero.

After reset the block sweeps the whole map to the free state before it takes its first command.

Top module: `page_alloc_map`

## Requirements
- R1: After reset, `req_ready` stays low while the map is cleared. It then rises, `free_pages` equals NUM_PAGES, and every page is free.
- R2: Command code 0 (top-down allocate) returns the highest-numbered free page. It pulses `rsp_done` for one cycle with `rsp_addr` = {page, 12'h000}, marks the page used and lowers `free_pages` by one.
- R3: Command code 1 (DMA allocate) returns the lowest-numbered free page. It pulses `rsp_done`, marks the page used and lowers `free_pages` by one.
- R4: A DMA allocate never returns a page at or above DMA_LIMIT_PAGES. If every page below that limit is used, it pulses `rsp_fail` and leaves the map and count unchanged.
- R5: An allocate accepted while `free_pages` is zero pulses `rsp_fail` in the very next cycle, without scanning.
- R6: Command code 2 (free) on a used page clears it, raises `free_pages` by one and pulses `rsp_done` with the page address.
- R7: Command code 2 on a page that is already free pulses `rsp_err`. The map and `free_pages` are unchanged.
- R8: Command code 3 (mark used) on a free page sets it and lowers `free_pages` by one. On a used page it changes nothing. Both cases pulse `rsp_done`.
- R9: Each accepted command produces exactly one of `rsp_done`, `rsp_fail` or `rsp_err`. `req_valid` is only taken while `req_ready` is high, and requests presented while it is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_op | input | 2 | 0 top-down allocate, 1 DMA allocate, 2 free, 3 mark used |
| req_page | input | PAGE_W | Page index for free and mark commands |
| req_ready | output | 1 | Block idle and able to take a command |
| rsp_done | output | 1 | Command completed |
| rsp_fail | output | 1 | Allocation found no eligible page |
| rsp_err | output | 1 | Free of a page that was already free |
| rsp_addr | output | PAGE_W+12 | Physical address of the page concerned |
| free_pages | output | CNT_W | Number of free pages |

## Verification
The bench builds the block with NUM_PAGES=64, WORD_W=8 and DMA_LIMIT_PAGES=16. The map is then eight words, so scans cross word boundaries in both directions. The DMA window is only two words, so it can be filled with a dozen mark commands while higher pages stay free, which exposes the limit. Draining the whole map takes under fifty requests, so the zero-count fast failure is also reached, and a reset in the middle of the run shows that the clearing sweep restores an all-free map.

// File: rtl/pab_pkg.sv
package pab_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC_HI  = 2'd0,
    OP_ALLOC_DMA = 2'd1,
    OP_FREE      = 2'd2,
    OP_MARK      = 2'd3
  } pab_op_e;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOOK,
    ST_EXAM
  } pab_state_e;

endpackage

// File: rtl/pab_ram.sv
module pab_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pab_pick.sv
module pab_pick #(
  parameter int WIDTH = 32,
  localparam int BW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] word,
  input  logic             from_top,
  output logic             found,
  output logic [BW-1:0]    idx
);

  logic [BW-1:0] hi_idx, lo_idx;

  // highest clear bit: ascending walk, last hit wins
  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < WIDTH; i++)
      if (!word[i]) hi_idx = BW'(i);
  end

  // lowest clear bit: descending walk, last hit wins
  always_comb begin
    lo_idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--)
      if (!word[i]) lo_idx = BW'(i);
  end

  assign found = ~&word;
  assign idx   = from_top ? hi_idx : lo_idx;

endmodule

// File: rtl/page_alloc_map.sv
module page_alloc_map
  import pab_pkg::*;
#(
  parameter int NUM_PAGES       = 16384,
  parameter int WORD_W          = 32,
  parameter int DMA_LIMIT_PAGES = 4096,
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int CNT_W     = $clog2(NUM_PAGES + 1),
  localparam int BW        = $clog2(WORD_W),
  localparam int NUM_WORDS = NUM_PAGES / WORD_W,
  localparam int AW        = $clog2(NUM_WORDS),
  localparam int DMA_PAGES = (DMA_LIMIT_PAGES < NUM_PAGES) ? DMA_LIMIT_PAGES : NUM_PAGES,
  localparam int DMA_WORDS = DMA_PAGES / WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [PAGE_W-1:0] req_page,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_fail,
  output logic              rsp_err,
  output logic [PAGE_W+11:0] rsp_addr,
  output logic [CNT_W-1:0]  free_pages
);

  pab_state_e        state;
  pab_op_e           op_q;
  logic [AW-1:0]     ptr;
  logic [BW-1:0]     bit_q;
  logic [CNT_W-1:0]  free_cnt;

  logic              ram_we;
  logic [AW-1:0]     ram_waddr;
  logic [WORD_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_rdata;

  logic              pick_found;
  logic [BW-1:0]     pick_idx;
  logic              is_alloc_q;
  logic              at_last;
  logic [AW-1:0]     ptr_next;
  logic [BW-1:0]     sel_bit;
  logic [WORD_W-1:0] sel_mask;
  logic              sel_used;
  logic              req_alloc;

  pab_ram #(.WIDTH(WORD_W), .DEPTH(NUM_WORDS)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ptr),
    .rdata (ram_rdata)
  );

  pab_pick #(.WIDTH(WORD_W)) u_pick (
    .word     (ram_rdata),
    .from_top (op_q == OP_ALLOC_HI),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  assign is_alloc_q = (op_q == OP_ALLOC_HI) || (op_q == OP_ALLOC_DMA);
  assign req_alloc  = (req_op == OP_ALLOC_HI) || (req_op == OP_ALLOC_DMA);
  assign at_last    = (op_q == OP_ALLOC_HI) ? (ptr == '0)
                                            : (ptr == AW'(DMA_WORDS - 1));
  assign ptr_next   = (op_q == OP_ALLOC_HI) ? ptr - 1'b1 : ptr + 1'b1;
  assign sel_bit    = is_alloc_q ? pick_idx : bit_q;
  assign sel_mask   = WORD_W'(1) << sel_bit;
  assign sel_used   = ram_rdata[bit_q];

  // read-modify-write of one map word
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = ptr;
    ram_wdata = ram_rdata;
    if (state == ST_INIT) begin
      ram_we    = 1'b1;
      ram_wdata = '0;
    end else if (state == ST_EXAM) begin
      unique case (op_q)
        OP_ALLOC_HI, OP_ALLOC_DMA: begin
          ram_we    = pick_found;
          ram_wdata = ram_rdata | sel_mask;
        end
        OP_FREE: begin
          ram_we    = sel_used;
          ram_wdata = ram_rdata & ~sel_mask;
        end
        OP_MARK: begin
          ram_we    = !sel_used;
          ram_wdata = ram_rdata | sel_mask;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_INIT;
      op_q     <= OP_ALLOC_HI;
      ptr      <= '0;
      bit_q    <= '0;
      free_cnt <= CNT_W'(NUM_PAGES);
      rsp_done <= 1'b0;
      rsp_fail <= 1'b0;
      rsp_err  <= 1'b0;
      rsp_addr <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_fail <= 1'b0;
      rsp_err  <= 1'b0;
      unique case (state)
        ST_INIT: begin
          ptr <= ptr + 1'b1;
          if (ptr == AW'(NUM_WORDS - 1)) begin
            ptr   <= '0;
            state <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            op_q  <= pab_op_e'(req_op);
            bit_q <= req_page[BW-1:0];
            if (req_alloc && free_cnt == '0) begin
              rsp_fail <= 1'b1;
            end else begin
              state <= ST_LOOK;
              unique case (pab_op_e'(req_op))
                OP_ALLOC_HI:  ptr <= AW'(NUM_WORDS - 1);
                OP_ALLOC_DMA: ptr <= '0;
                default:      ptr <= req_page[PAGE_W-1:BW];
              endcase
            end
          end
        end
        ST_LOOK: state <= ST_EXAM;
        ST_EXAM: begin
          state <= ST_IDLE;
          unique case (op_q)
            OP_ALLOC_HI, OP_ALLOC_DMA: begin
              if (pick_found) begin
                rsp_done <= 1'b1;
                rsp_addr <= {ptr, pick_idx, 12'h000};
                free_cnt <= free_cnt - 1'b1;
              end else if (at_last) begin
                rsp_fail <= 1'b1;
              end else begin
                ptr   <= ptr_next;
                state <= ST_LOOK;
              end
            end
            OP_FREE: begin
              rsp_addr <= {ptr, bit_q, 12'h000};
              if (sel_used) begin
                rsp_done <= 1'b1;
                free_cnt <= free_cnt + 1'b1;
              end else begin
                rsp_err  <= 1'b1;
              end
            end
            OP_MARK: begin
              rsp_addr <= {ptr, bit_q, 12'h000};
              rsp_done <= 1'b1;
              if (!sel_used) free_cnt <= free_cnt - 1'b1;
            end
          endcase
        end
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign free_pages = free_cnt;

  // R9
  resp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_done, rsp_fail, rsp_err}));

  // R4
  dma_window_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && op_q == OP_ALLOC_DMA) |-> (rsp_addr[PAGE_W+11:12] < PAGE_W'(DMA_PAGES)));

  // R5
  empty_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_alloc && free_pages == '0) |=> rsp_fail);

  // R7
  double_free_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $stable(free_pages));

  // R2
  alloc_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && is_alloc_q) |-> (free_pages == CNT_W'($past(free_pages) - 1'b1)));

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    free_pages <= CNT_W'(NUM_PAGES));

endmodule

// File: tb/sim_page_alloc_map.sv
`timescale 1ns/1ps
module sim_page_alloc_map;

  localparam int NP = 64;
  localparam int WW = 8;
  localparam int DL = 16;
  localparam int PW = $clog2(NP);
  localparam int CW = $clog2(NP + 1);

  localparam int K_DONE = 0;
  localparam int K_FAIL = 1;
  localparam int K_ERR  = 2;

  // {op[31:28], page[27:20], kind[19:16], exp_page[15:8], exp_count[7:0]}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {4'd0, 8'd0,  4'd0, 8'd63, 8'd63},  // R2 highest
    {4'd0, 8'd0,  4'd0, 8'd62, 8'd62},  // R2
    {4'd1, 8'd0,  4'd0, 8'd0,  8'd61},  // R3 lowest
    {4'd1, 8'd0,  4'd0, 8'd1,  8'd60},  // R3
    {4'd2, 8'd62, 4'd0, 8'd62, 8'd61},  // R6 free used page
    {4'd0, 8'd0,  4'd0, 8'd62, 8'd60},  // R2 reuses freed page
    {4'd2, 8'd5,  4'd2, 8'd5,  8'd60},  // R7 double free
    {4'd3, 8'd2,  4'd0, 8'd2,  8'd59},  // R8 mark free page
    {4'd1, 8'd0,  4'd0, 8'd3,  8'd58},  // R3 skips marked page
    {4'd3, 8'd3,  4'd0, 8'd3,  8'd58},  // R8 mark used page
    {4'd2, 8'd0,  4'd0, 8'd0,  8'd59},  // R6
    {4'd1, 8'd0,  4'd0, 8'd0,  8'd58},  // R3 reuse page 0
    {4'd0, 8'd0,  4'd0, 8'd61, 8'd57}   // R2 next down
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [PW-1:0] req_page = '0;
  logic          req_ready;
  logic          rsp_done, rsp_fail, rsp_err;
  logic [PW+11:0] rsp_addr;
  logic [CW-1:0] free_pages;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  page_alloc_map #(.NUM_PAGES(NP), .WORD_W(WW), .DMA_LIMIT_PAGES(DL)) u0 (
    .clk, .rst, .req_valid, .req_op, .req_page, .req_ready,
    .rsp_done, .rsp_fail, .rsp_err, .rsp_addr, .free_pages
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int op, input int pg,
                        output int kind, output int page, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_page  = PW'(pg);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!(rsp_done || rsp_fail || rsp_err) && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    kind = rsp_done ? K_DONE : rsp_fail ? K_FAIL : rsp_err ? K_ERR : 9;
    page = int'(rsp_addr >> 12);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!req_ready && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int kind, page, lat;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready low during clear", int'(req_ready), 0);
    wait_ready();
    chk("R1 ready after clear", int'(req_ready), 1);
    chk("R1 free count after reset", int'(free_pages), NP);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_req(int'(VEC[i][31:28]), int'(VEC[i][27:20]), kind, page, lat);
      chk($sformatf("R9 vec%0d response kind", i), kind, int'(VEC[i][19:16]));
      chk($sformatf("R2 vec%0d page", i), page, int'(VEC[i][15:8]));
      @(negedge clk);
      chk($sformatf("R6 vec%0d free count", i), int'(free_pages), int'(VEC[i][7:0]));
    end

    // fill the DMA window: pages 4..15
    for (int p = 4; p < DL; p++) do_req(3, p, kind, page, lat);
    @(negedge clk);
    chk("R8 count after marks", int'(free_pages), 45);
    do_req(1, 0, kind, page, lat);
    chk("R4 DMA fails with high pages free", kind, K_FAIL);
    @(negedge clk);
    chk("R4 count unchanged on DMA fail", int'(free_pages), 45);

    // drain the rest top-down: 60 down to 16
    for (int n = 0; n < 45; n++) begin
      do_req(0, 0, kind, page, lat);
      if (page != 60 - n || kind != K_DONE)
        chk("R2 drain order", page, 60 - n);
    end
    checks++;
    chk("R2 last drained page", page, 16);
    @(negedge clk);
    chk("R2 count drained", int'(free_pages), 0);
    do_req(0, 0, kind, page, lat);
    chk("R5 empty alloc fails", kind, K_FAIL);
    chk("R5 empty fail latency", lat, 1);
    do_req(1, 0, kind, page, lat);
    chk("R5 empty DMA fails", kind, K_FAIL);

    // request held high while busy is taken once
    @(negedge clk);
    wait_ready();
    req_valid = 1'b1;
    req_op    = 2'd2;
    req_page  = PW'(20);
    @(negedge clk);
    chk("R9 ready low while busy", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R6 held free completes", int'(rsp_done), 1);
    @(negedge clk);
    chk("R9 held request taken once", int'(free_pages), 1);
    do_req(2, 20, kind, page, lat);
    chk("R7 second free of page 20", kind, K_ERR);
    @(negedge clk);
    chk("R7 count unchanged", int'(free_pages), 1);
    do_req(1, 0, kind, page, lat);
    chk("R4 DMA ignores page 20", kind, K_FAIL);
    do_req(0, 0, kind, page, lat);
    chk("R2 only free page", page, 20);

    // reset mid-run clears the map
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready low after second reset", int'(req_ready), 0);
    wait_ready();
    chk("R1 count restored", int'(free_pages), NP);
    do_req(0, 0, kind, page, lat);
    chk("R1 map cleared top", page, 63);
    do_req(1, 0, kind, page, lat);
    chk("R1 map cleared bottom", page, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule